// File: doc/BRIEF.md
# Doorbell Mailbox with Dword Ring Buffers

This block is a two-way mailbox between a host processor and an embedded controller. The host reaches it through a 32-bit register bus addressed by word index. Each word written to the send window is pushed into a host-to-device ring. Each word read from the receive window pops the head of a device-to-host ring. The embedded controller sits on the far side. It has a plain push port, a pop port and a doorbell input.

Occupancy is never reported as a count. Each ring keeps free-running 8-bit read and write pointers, and both are exposed in status words. Software takes the write pointer minus the read pointer modulo 256 to get the number of filled slots. A result above the depth field means something went wrong.

The host control word carries five flags:
- interrupt enable;
- an interrupt-status flag that the device doorbell sets and that is cleared by writing one;
- a self-clearing doorbell flag that sends a one-cycle pulse to the device;
- host ready;
- a reset flag that empties both rings while it is held.

Top module: `mailbox_doorbell`

## Requirements
- R1: After reset both rings are empty, all pointers are 0 and every control flag is 0. The control word and the status word both read 0x0400_0000 with depth 4, and hostIrq, hostBell, hostReset and hostReady are 0.
- R2: A bus write to word 0 pushes regWrData into the host-to-device ring. devPopData shows the oldest word, with devPopValid high, and devPopEn pops it, in write order.
- R3: A bus read of word 2 returns the oldest device-to-host word and pops it. When that ring is empty the read returns 0 and no pointer moves.
- R4: Word 1, the control word, has this layout: bit 0 interrupt enable, bit 1 interrupt status, bit 2 doorbell (always reads 0), bit 3 host ready, bit 4 reset. Bits 15:8 hold the host-to-device read pointer, bits 23:16 its write pointer and bits 31:24 the depth. A write updates bits 0, 3 and 4 from regWrData. The pointer and depth fields are read-only.
- R5: Pointers are 8 bits and free-running, wrapping from 255 to 0. The filled count is the write pointer minus the read pointer modulo 256, and it never exceeds the depth.
- R6: A devBell pulse sets interrupt status. Writing the control word with bit 1 = 1 clears it, and writing bit 1 = 0 leaves it unchanged.
- R7: Writing the control word with bit 2 = 1 drives hostBell high for exactly the following cycle. Bit 2 always reads back 0.
- R8: hostIrq is high exactly when both interrupt status and interrupt enable are set.
- R9: While the reset flag is set, hostReset is high and both rings are emptied, with all four pointers forced to 0. The reset flag is cleared by a control write with bit 4 = 0.
- R10: Word 3, the device status word, has this layout: bit 0 the devReady input, bits 15:8 the device-to-host read pointer, bits 23:16 its write pointer and bits 31:24 the depth.
- R11: A push to a full ring is dropped and leaves its pointers unchanged. devPushFull reports a full device-to-host ring.
- R12: hostReady follows the host-ready flag in control bit 3. A single control write of 0x0D sets interrupt enable and host ready together and rings the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Bus write strobe |
| regRdEn | input | 1 | Bus read strobe (pops on word 2) |
| regWordAddr | input | 2 | Word index: 0 send window, 1 control, 2 receive window, 3 device status |
| regWrData | input | 32 | Bus write data |
| regRdData | output | 32 | Bus read data for the addressed word |
| hostIrq | output | 1 | Host interrupt request |
| hostBell | output | 1 | One-cycle doorbell pulse to the device |
| hostReset | output | 1 | Level of the reset flag |
| hostReady | output | 1 | Level of the host-ready flag |
| devReady | input | 1 | Device ready indication |
| devBell | input | 1 | Device doorbell; sets interrupt status |
| devPushEn | input | 1 | Device push into the device-to-host ring |
| devPushData | input | 32 | Device push data |
| devPushFull | output | 1 | Device-to-host ring is full |
| devPopEn | input | 1 | Device pop from the host-to-device ring |
| devPopData | output | 32 | Oldest host-to-device word (0 when empty) |
| devPopValid | output | 1 | Host-to-device ring holds data |

## Verification
The bench builds the block with DEPTH = 4. With that depth, a fifth push reaches the full-ring drop after only a few bus writes. It also makes the filled count easy to read in the pointer fields. A run of 300 push and pop pairs carries the 8-bit pointers past 255 and back through 0. The filled count is then checked to stay correct across that wrap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic h2dPush;
    logic d2hPop;
    logic flush;
  } mbx_strobe_t;

  typedef struct packed {
    logic [PTR_W-1:0]  h2dRd;
    logic [PTR_W-1:0]  h2dWr;
    logic [PTR_W-1:0]  d2hRd;
    logic [PTR_W-1:0]  d2hWr;
    logic [DATA_W-1:0] d2hHead;
  } mbx_ptrs_t;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       pushEn,
  input  logic [mbx_pkg::DATA_W-1:0] pushData,
  input  logic                       popEn,
  output logic [mbx_pkg::DATA_W-1:0] headData,
  output logic [mbx_pkg::PTR_W-1:0]  rdPtr,
  output logic [mbx_pkg::PTR_W-1:0]  wrPtr,
  output logic                       full,
  output logic                       empty
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [mbx_pkg::PTR_W-1:0] DEPTH8 = mbx_pkg::PTR_W'(DEPTH);

  logic [mbx_pkg::DATA_W-1:0] slots [DEPTH];
  logic [mbx_pkg::PTR_W-1:0]  filled;

  assign filled   = wrPtr - rdPtr;
  assign full     = (filled == DEPTH8);
  assign empty    = (filled == '0);
  assign headData = empty ? '0 : slots[rdPtr[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (pushEn && !full) wrPtr <= wrPtr + 1'b1;
      if (popEn && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushEn && !full && !flush) slots[wrPtr[IDX_W-1:0]] <= pushData;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mbx_pkg::mbx_strobe_t       strobe,
  input  logic [mbx_pkg::DATA_W-1:0] regWrData,
  input  logic                       devPushEn,
  input  logic [mbx_pkg::DATA_W-1:0] devPushData,
  output logic                       devPushFull,
  input  logic                       devPopEn,
  output logic [mbx_pkg::DATA_W-1:0] devPopData,
  output logic                       devPopValid,
  output mbx_pkg::mbx_ptrs_t         ptrs
);
  logic h2dEmpty, unusedH2dFull, unusedD2hEmpty;

  mbx_ring #(.DEPTH(DEPTH)) h2dRing (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .pushEn(strobe.h2dPush), .pushData(regWrData),
    .popEn(devPopEn), .headData(devPopData),
    .rdPtr(ptrs.h2dRd), .wrPtr(ptrs.h2dWr),
    .full(unusedH2dFull), .empty(h2dEmpty)
  );

  mbx_ring #(.DEPTH(DEPTH)) d2hRing (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .pushEn(devPushEn), .pushData(devPushData),
    .popEn(strobe.d2hPop), .headData(ptrs.d2hHead),
    .rdPtr(ptrs.d2hRd), .wrPtr(ptrs.d2hWr),
    .full(devPushFull), .empty(unusedD2hEmpty)
  );

  assign devPopValid = !h2dEmpty;
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [1:0]                 regWordAddr,
  input  logic [4:0]                 ctrlWrBits,
  input  logic                       devReady,
  input  logic                       devBell,
  input  mbx_pkg::mbx_ptrs_t         ptrs,
  output mbx_pkg::mbx_strobe_t       strobe,
  output logic [mbx_pkg::DATA_W-1:0] regRdData,
  output logic                       hostIrq,
  output logic                       hostBell,
  output logic                       hostReset,
  output logic                       hostReady
);
  localparam logic [1:0] ADDR_SEND = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_RECV = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic intEn, intStat, ctrlWr;

  assign ctrlWr = regWrEn && (regWordAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn     <= 1'b0;
      intStat   <= 1'b0;
      hostReady <= 1'b0;
      hostReset <= 1'b0;
      hostBell  <= 1'b0;
    end else begin
      hostBell <= ctrlWr && ctrlWrBits[2];
      if (ctrlWr) begin
        intEn     <= ctrlWrBits[0];
        hostReady <= ctrlWrBits[3];
        hostReset <= ctrlWrBits[4];
      end
      if (devBell)                          intStat <= 1'b1;
      else if (ctrlWr && ctrlWrBits[1])     intStat <= 1'b0;
    end
  end

  assign hostIrq = intStat && intEn;

  always_comb begin
    strobe.h2dPush = regWrEn && (regWordAddr == ADDR_SEND);
    strobe.d2hPop  = regRdEn && (regWordAddr == ADDR_RECV);
    strobe.flush   = hostReset;
  end

  always_comb begin
    case (regWordAddr)
      ADDR_CTRL: regRdData = {DEPTH8, ptrs.h2dWr, ptrs.h2dRd, 3'b000,
                              hostReset, hostReady, 1'b0, intStat, intEn};
      ADDR_RECV: regRdData = ptrs.d2hHead;
      ADDR_STAT: regRdData = {DEPTH8, ptrs.d2hWr, ptrs.d2hRd, 7'd0, devReady};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mailbox_doorbell.sv
module mailbox_doorbell #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regWordAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        hostIrq,
  output logic        hostBell,
  output logic        hostReset,
  output logic        hostReady,
  input  logic        devReady,
  input  logic        devBell,
  input  logic        devPushEn,
  input  logic [31:0] devPushData,
  output logic        devPushFull,
  input  logic        devPopEn,
  output logic [31:0] devPopData,
  output logic        devPopValid
);
  mbx_pkg::mbx_strobe_t strobe;
  mbx_pkg::mbx_ptrs_t   dpStat;

  mbx_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWordAddr(regWordAddr), .ctrlWrBits(regWrData[4:0]),
    .devReady(devReady), .devBell(devBell), .ptrs(dpStat),
    .strobe(strobe), .regRdData(regRdData), .hostIrq(hostIrq),
    .hostBell(hostBell), .hostReset(hostReset), .hostReady(hostReady)
  );

  mbx_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .devPushEn(devPushEn), .devPushData(devPushData),
    .devPushFull(devPushFull), .devPopEn(devPopEn),
    .devPopData(devPopData), .devPopValid(devPopValid), .ptrs(dpStat)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [1:0]         regWordAddr,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic               hostIrq,
  input logic               hostBell,
  input logic               hostReset,
  input logic               devBell,
  input mbx_pkg::mbx_ptrs_t ptrs
);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  assert_bell_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostBell |-> $past(regWrEn && regWordAddr == 2'd1 && regWrData[2]));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> ($past(devBell) ||
                        $past(regWrEn && regWordAddr == 2'd1 && regWrData[0])));

  assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (8'(ptrs.h2dWr - ptrs.h2dRd) <= DEPTH8) && (8'(ptrs.d2hWr - ptrs.d2hRd) <= DEPTH8));

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (8'(ptrs.h2dWr - ptrs.h2dRd) == DEPTH8 && regWrEn && regWordAddr == 2'd0 && !hostReset)
      |=> $stable(ptrs.h2dWr));

  assert_empty_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regWordAddr == 2'd2 && ptrs.d2hWr == ptrs.d2hRd) |-> (regRdData == 32'd0));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostReset |=> (ptrs.h2dRd == 8'd0 && ptrs.h2dWr == 8'd0 &&
                   ptrs.d2hRd == 8'd0 && ptrs.d2hWr == 8'd0));
endmodule

bind mailbox_doorbell mbx_checker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regWordAddr(regWordAddr), .regWrData(regWrData), .regRdData(regRdData),
  .hostIrq(hostIrq), .hostBell(hostBell), .hostReset(hostReset),
  .devBell(devBell), .ptrs(dpStat)
);

// File: tb/mailbox_doorbell_test.sv
`timescale 1ns/1ps
module mailbox_doorbell_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0, devReady = 0, devBell = 0;
  logic devPushEn = 0, devPopEn = 0;
  logic [1:0] regWordAddr = '0;
  logic [31:0] regWrData = '0, devPushData = '0;
  logic [31:0] regRdData, devPopData;
  logic hostIrq, hostBell, hostReset, hostReady, devPushFull, devPopValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mailbox_doorbell #(.DEPTH(4)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWordAddr(regWordAddr), .regWrData(regWrData), .regRdData(regRdData),
    .hostIrq(hostIrq), .hostBell(hostBell), .hostReset(hostReset),
    .hostReady(hostReady), .devReady(devReady), .devBell(devBell),
    .devPushEn(devPushEn), .devPushData(devPushData), .devPushFull(devPushFull),
    .devPopEn(devPopEn), .devPopData(devPopData), .devPopValid(devPopValid)
  );

  // {op (0 write, 1 read-check), word address, write data, expected}
  localparam int NVEC = 9;
  localparam logic [67:0] VECS [NVEC] = '{
    {2'd0, 2'd0, 32'h1111_1111, 32'h0},
    {2'd0, 2'd0, 32'h2222_2222, 32'h0},
    {2'd1, 2'd1, 32'h0,         32'h0402_0000},
    {2'd0, 2'd1, 32'h0000_0009, 32'h0},
    {2'd1, 2'd1, 32'h0,         32'h0402_0009},
    {2'd1, 2'd2, 32'h0,         32'h0},
    {2'd1, 2'd3, 32'h0,         32'h0400_0000},
    {2'd0, 2'd1, 32'h0,         32'h0},
    {2'd1, 2'd1, 32'h0,         32'h0402_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1; regWordAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    regRdEn = 1; regWordAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic devPop(output logic [31:0] d);
    devPopEn = 1;
    #1 d = devPopData;
    @(negedge clk);
    devPopEn = 0;
  endtask

  task automatic devPush(input logic [31:0] d);
    devPushEn = 1; devPushData = d;
    @(negedge clk);
    devPushEn = 0;
  endtask

  task automatic ringBell();
    devBell = 1;
    @(negedge clk);
    devBell = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    readCheck("R1 control", 2'd1, 32'h0400_0000);
    readCheck("R1 status", 2'd3, 32'h0400_0000);
    check("R1 irq/bell/reset/ready", {28'd0, hostIrq, hostBell, hostReset, hostReady}, 32'h0);

    // table walk: control word layout R4, empty pop R3, status R10
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][67:66] == 2'd0) busWrite(VECS[i][65:64], VECS[i][63:32]);
      else readCheck($sformatf("R4 vector %0d", i), VECS[i][65:64], VECS[i][31:0]);
    end

    // R2 device receives in order
    devPop(d); check("R2 first word", d, 32'h1111_1111);
    devPop(d); check("R2 second word", d, 32'h2222_2222);
    check("R2 valid drops", {31'd0, devPopValid}, 32'd0);

    // R11 full ring drops the fifth push
    for (int i = 0; i < 5; i++) busWrite(2'd0, 32'hA000_0000 + i);
    readCheck("R11 pointers after overfill", 2'd1, 32'h0406_0200);
    for (int i = 0; i < 4; i++) begin
      devPop(d); check("R11 kept word", d, 32'hA000_0000 + i);
    end
    check("R11 nothing left", {31'd0, devPopValid}, 32'd0);

    // R3 host reads device words in order, empty returns zero
    devReady = 1;
    devPush(32'hB000_0000);
    devPush(32'hB000_0001);
    readCheck("R3 first word", 2'd2, 32'hB000_0000);
    readCheck("R3 second word", 2'd2, 32'hB000_0001);
    readCheck("R3 empty read zero", 2'd2, 32'h0);
    readCheck("R10 status pointers unchanged", 2'd3, 32'h0402_0201);
    for (int i = 0; i < 4; i++) devPush(32'hC0 + i);
    check("R11 device full flag", {31'd0, devPushFull}, 32'd1);
    devPush(32'hDEAD);
    readCheck("R11 device push dropped", 2'd3, 32'h0406_0201);
    for (int i = 0; i < 4; i++) readCheck("R3 drain", 2'd2, 32'hC0 + i);

    // R6 / R8 interrupt status and enable
    busWrite(2'd1, 32'h1);
    ringBell();
    check("R8 irq with enable", {31'd0, hostIrq}, 32'd1);
    readCheck("R6 status set", 2'd1, 32'h0406_0603);
    busWrite(2'd1, 32'h1);
    check("R6 write zero keeps", {31'd0, hostIrq}, 32'd1);
    busWrite(2'd1, 32'h3);
    check("R6 write one clears", {31'd0, hostIrq}, 32'd0);
    readCheck("R6 status cleared", 2'd1, 32'h0406_0601);
    busWrite(2'd1, 32'h0);
    ringBell();
    check("R8 masked irq", {31'd0, hostIrq}, 32'd0);
    busWrite(2'd1, 32'h1);
    check("R8 irq after enable", {31'd0, hostIrq}, 32'd1);
    busWrite(2'd1, 32'h3);

    // R7 doorbell pulse
    busWrite(2'd1, 32'h4);
    check("R7 bell high", {31'd0, hostBell}, 32'd1);
    @(negedge clk);
    check("R7 bell one cycle", {31'd0, hostBell}, 32'd0);
    readCheck("R7 bell reads zero", 2'd1, 32'h0406_0600);

    // R5 pointer wrap past 255
    for (int i = 0; i < 300; i++) begin
      busWrite(2'd0, i);
      devPop(d);
    end
    busWrite(2'd0, 32'h5555);
    readCheck("R5 wrapped pointers", 2'd1, 32'h0433_3200);
    devPop(d); check("R5 data after wrap", d, 32'h5555);

    // R9 reset sequence
    busWrite(2'd0, 32'h77);
    busWrite(2'd1, 32'h14);
    check("R9 reset level", {30'd0, hostReset, hostBell}, 32'h3);
    @(negedge clk);
    readCheck("R9 flushed", 2'd1, 32'h0400_0010);
    busWrite(2'd1, 32'h4);
    check("R9 reset released", {31'd0, hostReset}, 32'd0);
    readCheck("R9 control after", 2'd1, 32'h0400_0000);
    readCheck("R9 status after", 2'd3, 32'h0400_0001);
    check("R9 ring empty", {31'd0, devPopValid}, 32'd0);

    // R12 host ready
    busWrite(2'd1, 32'hD);
    check("R12 ready and bell", {30'd0, hostReady, hostBell}, 32'h3);
    readCheck("R12 control", 2'd1, 32'h0400_0009);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule